// File: doc/BRIEF.md
# Serial Code-Group Aligner and 5B/4B Nibble Decoder

This block sits behind the descrambler of a 100 Mb/s receive path. It takes the descrambled line stream one bit per clock and, while no frame is in progress, slides a ten-bit window over it one bit at a time, looking for the start-of-stream delimiter pair J followed by K. The bit position where that pair is found fixes the five-bit code-group boundary, and the block keeps that boundary until the frame ends. Code groups later in the frame that look like a delimiter do not move it.

Inside a frame, every five-bit code group becomes a four-bit nibble on an internal MII-like interface. The interface has a nibble bus, a data-valid flag, carrier sense and a receive error flag. The J/K pair itself is replaced by two preamble nibbles 0101. The frame ends on the end-of-stream pair T then R, or on two IDLE groups in a row, and none of those groups ever shows up as data. Each code group is held in a one-group pending stage so that the block can tell a closing pair from a lone T or IDLE before anything is driven out.

Top module: `rx_cg_decoder`

## Requirements
- R1: Bits are taken one per clock on `ser_bit`, and the first bit on the line is the leftmost bit of a code group as written. Out of frame, the pair J = 11000 and K = 10001 is found at any bit offset. `rx_dv` and `crs` go high on the clock edge after the edge that samples the last bit of K.
- R2: Once a frame starts, the code-group boundary stays fixed until the frame ends. A J (11000) or K (10001) group inside a frame is reported as an error nibble and does not realign the groups that follow.
- R3: The first two nibble periods of a frame, five clocks each, carry `rxd` = 0101 with `rx_dv` high and `rx_er` low.
- R4: Data groups decode as 0=11110, 1=01001, 2=10100, 3=10101, 4=01010, 5=01011, 6=01110, 7=01111, 8=10010, 9=10011, A=10110, B=10111, C=11010, D=11011, E=11100, F=11101. Each nibble is held for five clocks. It appears on the sixth edge after the edge that samples the last bit of its group.
- R5: T = 01101 followed directly by R = 00111 drops `rx_dv` and `crs` together, at the point where T's nibble would have appeared. Neither T nor R is output as data.
- R6: Two consecutive IDLE groups (11111) end the frame in the same way as R5, at the point where the first IDLE's nibble would have appeared. The IDLEs are not output as data.
- R7: A five-bit pattern that is not in the R4 table (for example 00000) inside a frame raises `rx_er` for exactly that nibble period, with `rx_dv` still high. `rx_er` is low in every period that carries a valid data or preamble nibble.
- R8: Out of frame, `rxd` is 0 and `rx_dv`, `crs` and `rx_er` are low. A stream that never contains the J/K pair leaves them there.
- R9: While `rst_n` is low at a clock edge, all outputs clear and the window is refilled with ones.
- R10: A T not followed by R, or a single IDLE followed by any other group, is output as an error nibble as in R7, and the frame continues.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one line bit per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_bit | input | 1 | Descrambled serial line bit |
| rxd | output | 4 | Decoded nibble |
| rx_dv | output | 1 | Receive data valid |
| crs | output | 1 | Carrier sense |
| rx_er | output | 1 | Receive error for the current nibble |

## Verification
The assertions assume the following about the inputs:
- A new line bit arrives on every clock with no gaps.
- Reset has refilled the window with ones before any frame.
- Carrier can only rise out of a window that held the exact J/K pattern.

The stimulus meets these assumptions in three ways. It builds every stream from whole five-bit groups after an idle run of ones. It varies that run's length so the delimiter lands at different bit offsets. It drives exactly one bit per clock from the first edge after reset until the stream is exhausted.

// File: rtl/cgd_pkg.sv
// Package: shared constants and the code-group class type for the
// serial aligner / nibble decoder. Assumes 5-bit groups, 4-bit nibbles.
package cgd_pkg;
    localparam int SYM_W = 5;
    localparam int NIB_W = 4;
    localparam int WIN_W = 2 * SYM_W;
    localparam int CNT_W = $clog2(SYM_W + 1);

    localparam logic [SYM_W-1:0] CG_J    = 5'b11000;
    localparam logic [SYM_W-1:0] CG_K    = 5'b10001;
    localparam logic [SYM_W-1:0] CG_T    = 5'b01101;
    localparam logic [SYM_W-1:0] CG_R    = 5'b00111;
    localparam logic [SYM_W-1:0] CG_IDLE = 5'b11111;

    localparam logic [NIB_W-1:0] PRE_NIB = 4'b0101;

    typedef enum logic [2:0] {
        CK_DATA,
        CK_J,
        CK_K,
        CK_T,
        CK_R,
        CK_IDLE,
        CK_BAD
    } cg_kind_e;
endpackage

// File: rtl/cgd_shifter.sv
// Module: serial-in window. Shifts one line bit per clock into the LSB,
// so the oldest bit sits at the MSB. Assumes a continuous bit stream.
// Reset fills the window with ones (line idle) so no false delimiter.
module cgd_shifter #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         din,
    output logic [W-1:0] win
);
    // Purpose: slide the window by one bit each clock.
    always_ff @(posedge clk) begin
        if (!rst_n) win <= '1;
        else        win <= {win[W-2:0], din};
    end

    // R1: newest bit always lands in the LSB on the next edge
    a_r1_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> win[0] == $past(din));
endmodule

// File: rtl/cgd_sym_decode.sv
// Module: combinational classifier of one 5-bit code group into a kind
// and, for data groups, its 4-bit value. Assumes the group is bit-aligned.
module cgd_sym_decode
    import cgd_pkg::*;
(
    input  logic [SYM_W-1:0] code,
    output cg_kind_e         kind,
    output logic [NIB_W-1:0] nib
);
    // Purpose: map the group onto the data table or a control class.
    always_comb begin
        kind = CK_DATA;
        nib  = '0;
        case (code)
            5'b11110: nib = 4'h0;
            5'b01001: nib = 4'h1;
            5'b10100: nib = 4'h2;
            5'b10101: nib = 4'h3;
            5'b01010: nib = 4'h4;
            5'b01011: nib = 4'h5;
            5'b01110: nib = 4'h6;
            5'b01111: nib = 4'h7;
            5'b10010: nib = 4'h8;
            5'b10011: nib = 4'h9;
            5'b10110: nib = 4'hA;
            5'b10111: nib = 4'hB;
            5'b11010: nib = 4'hC;
            5'b11011: nib = 4'hD;
            5'b11100: nib = 4'hE;
            5'b11101: nib = 4'hF;
            CG_J:     kind = CK_J;
            CG_K:     kind = CK_K;
            CG_T:     kind = CK_T;
            CG_R:     kind = CK_R;
            CG_IDLE:  kind = CK_IDLE;
            default:  kind = CK_BAD;
        endcase
    end
endmodule

// File: rtl/rx_cg_decoder.sv
// Module: top of the aligner / decoder. Hunts for J/K out of frame,
// then counts fixed 5-bit groups, keeps one group pending to recognise
// T/R and IDLE/IDLE closings, and drives the nibble interface.
// Assumes one descrambled bit per clock, first-on-line bit = group MSB.
module rx_cg_decoder
    import cgd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_bit,
    output logic [NIB_W-1:0] rxd,
    output logic             rx_dv,
    output logic             crs,
    output logic             rx_er
);
    logic [WIN_W-1:0] win;
    cg_kind_e         cur_kind;
    logic [NIB_W-1:0] cur_nib;

    cgd_shifter #(.W(WIN_W)) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ser_bit),
        .win   (win)
    );

    cgd_sym_decode u_dec (
        .code (win[SYM_W-1:0]),
        .kind (cur_kind),
        .nib  (cur_nib)
    );

    logic             in_frame;
    logic [CNT_W-1:0] bit_cnt;
    logic             pend_pre;
    cg_kind_e         pend_kind;
    logic [NIB_W-1:0] pend_nib;

    logic jk_hit, sym_done, end_now;

    // Purpose: decode the hunt hit, the group boundary and the closing pair.
    always_comb begin
        jk_hit   = !in_frame && (win == {CG_J, CG_K});
        sym_done = in_frame && (bit_cnt == CNT_W'(SYM_W));
        end_now  = sym_done && !pend_pre &&
                   ((pend_kind == CK_T    && cur_kind == CK_R) ||
                    (pend_kind == CK_IDLE && cur_kind == CK_IDLE));
    end

    // Purpose: frame state, group counter and the one-group pending stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame  <= 1'b0;
            bit_cnt   <= '0;
            pend_pre  <= 1'b0;
            pend_kind <= CK_BAD;
            pend_nib  <= '0;
        end else if (jk_hit) begin
            in_frame <= 1'b1;
            bit_cnt  <= CNT_W'(1);
            pend_pre <= 1'b1;
        end else if (sym_done) begin
            bit_cnt   <= CNT_W'(1);
            pend_pre  <= 1'b0;
            pend_kind <= cur_kind;
            pend_nib  <= cur_nib;
            if (end_now) in_frame <= 1'b0;
        end else if (in_frame) begin
            bit_cnt <= bit_cnt + CNT_W'(1);
        end
    end

    // Purpose: drive the nibble interface once per group boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxd   <= '0;
            rx_dv <= 1'b0;
            crs   <= 1'b0;
            rx_er <= 1'b0;
        end else if (jk_hit) begin
            rxd   <= PRE_NIB;
            rx_dv <= 1'b1;
            crs   <= 1'b1;
            rx_er <= 1'b0;
        end else if (sym_done) begin
            if (end_now) begin
                rxd   <= '0;
                rx_dv <= 1'b0;
                crs   <= 1'b0;
                rx_er <= 1'b0;
            end else if (pend_pre) begin
                rxd   <= PRE_NIB;
                rx_er <= 1'b0;
            end else if (pend_kind == CK_DATA) begin
                rxd   <= pend_nib;
                rx_er <= 1'b0;
            end else begin
                rxd   <= '0;
                rx_er <= 1'b1;
            end
        end
    end

    // R1: carrier only rises out of a window that held J then K
    a_r1_start_on_jk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_dv) |-> $past(win) == {CG_J, CG_K});

    // R3: the first nibble of every frame is the preamble pattern
    a_r3_preamble_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_dv) |-> rxd == PRE_NIB);

    // R4: between group boundaries the nibble bus does not move
    a_r4_hold_nibble: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame && !sym_done) |=> $stable(rxd) && $stable(rx_dv));

    // R5: a frame only closes on a group boundary
    a_r5_end_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_dv) |-> $past(sym_done));

    // R7: the error flag is only raised inside a frame
    a_r7_err_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        rx_er |-> rx_dv && crs);
endmodule

// File: tb/rx_cg_decoder_test.sv
module rx_cg_decoder_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_bit = 1'b1;
    logic [3:0] rxd;
    logic       rx_dv, crs, rx_er;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;  // 250 MHz

    rx_cg_decoder uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .ser_bit (ser_bit),
        .rxd     (rxd),
        .rx_dv   (rx_dv),
        .crs     (crs),
        .rx_er   (rx_er)
    );

    logic       sbits [0:511];
    int         slen;
    logic [6:0] rec   [0:511];   // {dv, crs, er, rxd}

    function automatic logic [4:0] enc(input logic [3:0] n);
        case (n)
            4'h0: enc = 5'b11110; 4'h1: enc = 5'b01001;
            4'h2: enc = 5'b10100; 4'h3: enc = 5'b10101;
            4'h4: enc = 5'b01010; 4'h5: enc = 5'b01011;
            4'h6: enc = 5'b01110; 4'h7: enc = 5'b01111;
            4'h8: enc = 5'b10010; 4'h9: enc = 5'b10011;
            4'hA: enc = 5'b10110; 4'hB: enc = 5'b10111;
            4'hC: enc = 5'b11010; 4'hD: enc = 5'b11011;
            4'hE: enc = 5'b11100; default: enc = 5'b11101;
        endcase
    endfunction

    localparam logic [4:0] J = 5'b11000, K = 5'b10001, T = 5'b01101,
                           R = 5'b00111, I = 5'b11111, BAD = 5'b00000;

    task automatic push_code(input logic [4:0] c);
        for (int i = 4; i >= 0; i--) begin
            sbits[slen] = c[i];
            slen++;
        end
    endtask

    task automatic push_ones(input int n);
        for (int i = 0; i < n; i++) begin
            sbits[slen] = 1'b1;
            slen++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n   = 1'b0;
        ser_bit = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        slen  = 0;
    endtask

    // bit k is sampled on edge k; rec[k] holds outputs after edge k
    task automatic run_stream();
        for (int k = 0; k < slen; k++) begin
            ser_bit = sbits[k];
            @(negedge clk);
            rec[k] = {rx_dv, crs, rx_er, rxd};
        end
        ser_bit = 1'b1;
    endtask

    task automatic chk(input string req, input int idx, input logic e_dv,
                       input logic e_crs, input logic e_er,
                       input logic [3:0] e_rxd, input bit use_rxd);
        logic [6:0] g;
        g = rec[idx];
        n_chk++;
        if (g[6] !== e_dv || g[5] !== e_crs || g[4] !== e_er ||
            (use_rxd && g[3:0] !== e_rxd)) begin
            n_fail++;
            $display("FAIL %s edge %0d: actual dv=%b crs=%b er=%b rxd=%h expected dv=%b crs=%b er=%b rxd=%h",
                     req, idx, g[6], g[5], g[4], g[3:0], e_dv, e_crs, e_er, e_rxd);
        end
    endtask

    // R9: outputs clear under reset
    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        n_chk++;
        if ({rx_dv, crs, rx_er, rxd} !== 7'd0) begin
            n_fail++;
            $display("FAIL R9 reset: actual %b expected 0000000",
                     {rx_dv, crs, rx_er, rxd});
        end
    endtask

    // R1 R3 R4 R5 R8: full data table, closed by T/R
    task automatic t_tr_frame();
        int jk;
        do_reset();
        push_ones(3);
        push_code(J);
        push_code(K);
        for (int n = 0; n < 16; n++) push_code(enc(4'(n)));
        push_code(T);
        push_code(R);
        push_ones(12);
        run_stream();
        jk = 3 + 10;
        chk("R1 before start", jk - 1, 0, 0, 0, 4'h0, 1);
        chk("R1 start edge",   jk,     1, 1, 0, 4'h5, 1);
        chk("R3 preamble 1",   jk + 2, 1, 1, 0, 4'h5, 1);
        chk("R3 preamble 2",   jk + 7, 1, 1, 0, 4'h5, 1);
        for (int n = 0; n < 16; n++)
            chk("R4 data nibble", jk + 12 + 5 * n, 1, 1, 0, 4'(n), 1);
        chk("R4 first edge of nibble 0", jk + 10, 1, 1, 0, 4'h0, 1);
        chk("R5 end on T/R",   jk + 10 + 5 * 16,     0, 0, 0, 4'h0, 1);
        chk("R8 idle after",   jk + 10 + 5 * 16 + 8, 0, 0, 0, 4'h0, 1);
    endtask

    // R6: frame closed by two IDLE groups, odd offset
    task automatic t_idle_end();
        int jk;
        do_reset();
        push_ones(7);
        push_code(J);
        push_code(K);
        push_code(enc(4'hA));
        push_code(enc(4'h3));
        push_code(enc(4'hC));
        push_code(I);
        push_code(I);
        push_ones(8);
        run_stream();
        jk = 7 + 10;
        chk("R1 offset start", jk,      1, 1, 0, 4'h5, 1);
        chk("R6 data A",       jk + 12, 1, 1, 0, 4'hA, 1);
        chk("R6 data C",       jk + 24, 1, 1, 0, 4'hC, 1);
        chk("R6 end on I/I",   jk + 25, 0, 0, 0, 4'h0, 1);
    endtask

    // R2 R7 R10: bad groups, lone IDLE, lone T, mid-frame J/K
    task automatic t_errors();
        int jk;
        do_reset();
        push_ones(4);
        push_code(J);
        push_code(K);
        push_code(enc(4'h1));   // k0
        push_code(BAD);         // k1
        push_code(enc(4'h2));   // k2
        push_code(I);           // k3
        push_code(enc(4'h3));   // k4
        push_code(T);           // k5
        push_code(enc(4'h4));   // k6
        push_code(J);           // k7
        push_code(K);           // k8
        push_code(enc(4'h9));   // k9
        push_code(T);           // k10
        push_code(R);           // k11
        push_ones(6);
        run_stream();
        jk = 4 + 10;
        chk("R7 clean data",     jk + 12,          1, 1, 0, 4'h1, 1);
        chk("R7 invalid group",  jk + 12 + 5,      1, 1, 1, 4'h0, 0);
        chk("R7 error cleared",  jk + 12 + 10,     1, 1, 0, 4'h2, 1);
        chk("R10 lone IDLE",     jk + 12 + 15,     1, 1, 1, 4'h0, 0);
        chk("R10 after IDLE",    jk + 12 + 20,     1, 1, 0, 4'h3, 1);
        chk("R10 lone T",        jk + 12 + 25,     1, 1, 1, 4'h0, 0);
        chk("R10 after T",       jk + 12 + 30,     1, 1, 0, 4'h4, 1);
        chk("R2 J in frame",     jk + 12 + 35,     1, 1, 1, 4'h0, 0);
        chk("R2 K in frame",     jk + 12 + 40,     1, 1, 1, 4'h0, 0);
        chk("R2 alignment kept", jk + 12 + 45,     1, 1, 0, 4'h9, 1);
        chk("R5 end after errs", jk + 10 + 5 * 10, 0, 0, 0, 4'h0, 1);
    endtask

    // R8: stream without J/K never opens a frame
    task automatic t_no_frame();
        int bad;
        do_reset();
        for (int i = 0; i < 120; i++) begin
            sbits[slen] = (i % 2 == 0);
            slen++;
        end
        push_code(enc(4'h8));
        push_code(T);
        push_code(R);
        push_ones(10);
        run_stream();
        bad = -1;
        for (int i = 0; i < slen; i++)
            if (rec[i] !== 7'd0 && bad < 0) bad = i;
        n_chk++;
        if (bad >= 0) begin
            n_fail++;
            $display("FAIL R8 no frame edge %0d: actual %b expected 0000000",
                     bad, rec[bad]);
        end
    endtask

    // R1: second frame at a new offset after the first closes
    task automatic t_back_to_back();
        int jk1, jk2;
        do_reset();
        push_ones(2);
        push_code(J);
        push_code(K);
        push_code(enc(4'h7));
        push_code(T);
        push_code(R);
        push_ones(3);
        push_code(J);
        push_code(K);
        push_code(enc(4'hE));
        push_code(I);
        push_code(I);
        push_ones(6);
        run_stream();
        jk1 = 12;
        jk2 = jk1 + 28;
        chk("R4 frame1 data",   jk1 + 12, 1, 1, 0, 4'h7, 1);
        chk("R5 frame1 end",    jk1 + 15, 0, 0, 0, 4'h0, 1);
        chk("R1 gap low",       jk2 - 1,  0, 0, 0, 4'h0, 1);
        chk("R1 realigned",     jk2,      1, 1, 0, 4'h5, 1);
        chk("R4 frame2 data",   jk2 + 12, 1, 1, 0, 4'hE, 1);
        chk("R6 frame2 end",    jk2 + 15, 0, 0, 0, 4'h0, 1);
    endtask

    initial begin
        t_reset();
        t_tr_frame();
        t_idle_end();
        t_errors();
        t_no_frame();
        t_back_to_back();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual still running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule